// File: doc/BRIEF.md
# Video RAM Fill and Copy DMA Engine

This engine runs the two in-memory transfer modes of a video controller on a 64K-byte video RAM through a byte-wide port that takes one access per clock. In copy mode it reads a byte from a source address and writes it to a destination address, once per length step. In fill mode it writes bytes of a 16-bit fill word along the destination.

A copy starts on an accepted start pulse. A fill is only armed by its start pulse. It begins on the next data-port write, which also supplies the fill word. After each step the destination advances by an 8-bit auto-increment value. At the end the engine presents the values that go back into the host's registers: the remaining length (zero), the final source and the final destination. It then raises a one-cycle done strobe.

The RAM port has a read latency of one cycle: the byte read at the address presented with `mem_re_o` arrives on `mem_rdata_i` in the following cycle.

Top module: `vram_dma_engine`

## Requirements
- R1: The 16-bit length `len_i` gives the number of steps, and a value of 0 means 65536 steps.
- R2: Copy (`mode_i`=0) performs each step as a read cycle at the source address followed at once by a write cycle at the destination address. The write carries the byte returned by that read. The source then advances by 1 and the destination by `inc_i`, both modulo 65536.
- R3: Fill (`mode_i`=1) first writes the low byte (bits 7:0) of the fill word once at the destination address. It then repeats one write per step: the high byte (bits 15:8) goes to the destination address with bit 0 inverted, and the destination then advances by `inc_i` modulo 65536.
- R4: At most one RAM access happens per cycle: `mem_re_o` and `mem_we_o` are never high together.
- R5: `busy_o` is high in every cycle that holds a RAM access of the transfer, and only then. A copy of N steps keeps it high for 2N cycles and a fill for N+1 cycles. `done_o` is high for exactly one cycle, the first cycle after `busy_o` falls.
- R6: While `done_o` is high, `len_o` is 0 and `dst_o` holds the final destination. In copy mode `src_o` holds the final source (start source plus step count, modulo 65536) and `src_upd_o` is 1. After a fill, `src_upd_o` is 0.
- R7: An accepted fill start raises `armed_o` without starting any access. The next `data_wr_i` pulse latches `fill_word_i` and begins the fill. `armed_o` falls when the fill ends. A `data_wr_i` pulse while not armed causes no access.
- R8: A start pulse is ignored while `busy_o` or `armed_o` is high. The transfer in progress, or the armed fill setup, is unchanged.
- R9: After reset, `busy_o`, `armed_o`, `done_o`, `mem_re_o` and `mem_we_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle start request |
| mode_i | input | 1 | 0 = copy, 1 = fill |
| len_i | input | 16 | Step count, 0 means 65536 |
| src_i | input | 16 | Copy source address |
| dst_i | input | 16 | Destination address |
| inc_i | input | 8 | Destination auto-increment |
| data_wr_i | input | 1 | Data-port write strobe that begins an armed fill |
| fill_word_i | input | 16 | Fill word, sampled with data_wr_i |
| mem_addr_o | output | 16 | RAM byte address |
| mem_re_o | output | 1 | RAM read enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_wdata_o | output | 8 | RAM write byte |
| mem_rdata_i | input | 8 | RAM read byte, one cycle after mem_re_o |
| busy_o | output | 1 | Transfer in progress |
| armed_o | output | 1 | Fill armed or running |
| done_o | output | 1 | One-cycle end strobe, qualifies the writeback outputs |
| src_upd_o | output | 1 | Source writeback valid (copy only) |
| len_o | output | 16 | Remaining length for writeback |
| src_o | output | 16 | Current/final source address |
| dst_o | output | 16 | Current/final destination address |

## Verification
The assertions assume that `mem_rdata_i` returns the addressed byte in the cycle after a read. They also assume that `start_i` and `data_wr_i` are single-cycle pulses driven from reset-clean values. The bench holds to both. Its RAM model registers a byte computed from the address on each read. All strobes are driven for one cycle between clock edges. Start and data-write pulses during a run or while armed are applied only as deliberate misuse, to show that they are ignored. Every RAM access is matched in order against an expected list built from the requirements.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CP_RD,
    ST_CP_WR,
    ST_FL_LO,
    ST_FL_HI
  } vdma_state_e;

  localparam logic MODE_COPY = 1'b0;
  localparam logic MODE_FILL = 1'b1;
endpackage

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        mode_i,
  input  logic        data_wr_i,
  input  logic        last_i,
  output vdma_state_e state_o,
  output logic        load_o,
  output logic        word_o,
  output logic        step_o,
  output logic        src_step_o,
  output logic        busy_o,
  output logic        armed_o,
  output logic        done_o,
  output logic        src_upd_o
);
  vdma_state_e state_q, state_d;
  logic armed_q, done_q, upd_q;
  logic occupied, begin_fill, finish;

  assign occupied   = (state_q != ST_IDLE) || armed_q;
  assign load_o     = start_i && !occupied;
  assign begin_fill = data_wr_i && armed_q && (state_q == ST_IDLE);
  assign word_o     = begin_fill;
  assign step_o     = (state_q == ST_CP_WR) || (state_q == ST_FL_HI);
  assign src_step_o = (state_q == ST_CP_WR);
  assign finish     = step_o && last_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load_o && mode_i == MODE_COPY) state_d = ST_CP_RD;
        else if (begin_fill)               state_d = ST_FL_LO;
      end
      ST_CP_RD: state_d = ST_CP_WR;
      ST_CP_WR: state_d = last_i ? ST_IDLE : ST_CP_RD;
      ST_FL_LO: state_d = ST_FL_HI;
      ST_FL_HI: state_d = last_i ? ST_IDLE : ST_FL_HI;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      upd_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (load_o && mode_i == MODE_FILL)          armed_q <= 1'b1;
      else if (state_q == ST_FL_HI && last_i)     armed_q <= 1'b0;
      done_q <= finish;
      upd_q  <= finish && (state_q == ST_CP_WR);
    end
  end

  assign state_o   = state_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign armed_o   = armed_q;
  assign done_o    = done_q;
  assign src_upd_o = upd_q;

  p_rd_then_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_CP_RD |=> state_q == ST_CP_WR);
  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE) && ($past(state_q) != ST_IDLE));
  p_fill_armed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FL_LO || state_q == ST_FL_HI) |-> armed_q);
endmodule

// File: rtl/vdma_datapath.sv
module vdma_datapath #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]   dst_i,
  input  logic [INC_W-1:0]    inc_i,
  input  logic                word_i,
  input  logic [2*DATA_W-1:0] fill_word_i,
  input  logic                step_i,
  input  logic                src_step_i,
  output logic [ADDR_W-1:0]   src_o,
  output logic [ADDR_W-1:0]   dst_o,
  output logic [LEN_W-1:0]    len_o,
  output logic [DATA_W-1:0]   lo_o,
  output logic [DATA_W-1:0]   hi_o,
  output logic                last_o
);
  localparam int CNT_W = LEN_W + 1;

  logic [ADDR_W-1:0]   src_q, dst_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [INC_W-1:0]    inc_q;
  logic [2*DATA_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      dst_q  <= '0;
      cnt_q  <= '0;
      inc_q  <= '0;
      word_q <= '0;
    end else begin
      if (load_i) begin
        src_q <= src_i;
        dst_q <= dst_i;
        inc_q <= inc_i;
        // zero length encodes the full 2^LEN_W span
        cnt_q <= (len_i == '0) ? {1'b1, {LEN_W{1'b0}}} : {1'b0, len_i};
      end else begin
        if (src_step_i) src_q <= src_q + ADDR_W'(1);
        if (step_i) begin
          dst_q <= dst_q + ADDR_W'(inc_q);
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
      if (word_i) word_q <= fill_word_i;
    end
  end

  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign len_o  = cnt_q[LEN_W-1:0];
  assign last_o = (cnt_q == CNT_W'(1));
  assign lo_o   = word_q[DATA_W-1:0];
  assign hi_o   = word_q[2*DATA_W-1:DATA_W];

  p_src_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_step_i && !load_i) |=> src_q == ADDR_W'($past(src_q) + ADDR_W'(1)));
  p_dst_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> dst_q == ADDR_W'($past(dst_q) + ADDR_W'($past(inc_q))));
  p_cnt_nonzero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q != '0);
endmodule

// File: rtl/vdma_port.sv
module vdma_port
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  vdma_state_e       state_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              re_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o
);
  always_comb begin
    addr_o  = dst_i;
    re_o    = 1'b0;
    we_o    = 1'b0;
    wdata_o = '0;
    unique case (state_i)
      ST_CP_RD: begin
        addr_o = src_i;
        re_o   = 1'b1;
      end
      ST_CP_WR: begin
        we_o    = 1'b1;
        wdata_o = rdata_i;
      end
      ST_FL_LO: begin
        we_o    = 1'b1;
        wdata_o = lo_i;
      end
      ST_FL_HI: begin
        addr_o  = dst_i ^ ADDR_W'(1);
        we_o    = 1'b1;
        wdata_o = hi_i;
      end
      default: ;
    endcase
  end

  p_one_access_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(re_o && we_o));
  p_wr_follows_rd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_o |=> we_o);
endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
  import vdma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int INC_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic [ADDR_W-1:0]   src_i,
  input  logic [ADDR_W-1:0]   dst_i,
  input  logic [INC_W-1:0]    inc_i,
  input  logic                data_wr_i,
  input  logic [2*DATA_W-1:0] fill_word_i,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic                mem_re_o,
  output logic                mem_we_o,
  output logic [DATA_W-1:0]   mem_wdata_o,
  input  logic [DATA_W-1:0]   mem_rdata_i,
  output logic                busy_o,
  output logic                armed_o,
  output logic                done_o,
  output logic                src_upd_o,
  output logic [LEN_W-1:0]    len_o,
  output logic [ADDR_W-1:0]   src_o,
  output logic [ADDR_W-1:0]   dst_o
);
  vdma_state_e       state;
  logic              load, word, step, src_step, last;
  logic [DATA_W-1:0] lo_b, hi_b;

  vdma_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .data_wr_i  (data_wr_i),
    .last_i     (last),
    .state_o    (state),
    .load_o     (load),
    .word_o     (word),
    .step_o     (step),
    .src_step_o (src_step),
    .busy_o     (busy_o),
    .armed_o    (armed_o),
    .done_o     (done_o),
    .src_upd_o  (src_upd_o)
  );

  vdma_datapath #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .INC_W  (INC_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .len_i       (len_i),
    .src_i       (src_i),
    .dst_i       (dst_i),
    .inc_i       (inc_i),
    .word_i      (word),
    .fill_word_i (fill_word_i),
    .step_i      (step),
    .src_step_i  (src_step),
    .src_o       (src_o),
    .dst_o       (dst_o),
    .len_o       (len_o),
    .lo_o        (lo_b),
    .hi_o        (hi_b),
    .last_o      (last)
  );

  vdma_port #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_i (state),
    .src_i   (src_o),
    .dst_i   (dst_o),
    .lo_i    (lo_b),
    .hi_i    (hi_b),
    .rdata_i (mem_rdata_i),
    .addr_o  (mem_addr_o),
    .re_o    (mem_re_o),
    .we_o    (mem_we_o),
    .wdata_o (mem_wdata_o)
  );

  p_len_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> len_o == '0);
  p_start_ignored_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
  p_busy_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (mem_re_o || mem_we_o));
endmodule

// File: tb/sim_vram_dma_engine.sv
module sim_vram_dma_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, mode = 1'b0, data_wr = 1'b0;
  logic [15:0] len = '0, src = '0, dst = '0, fill_word = '0;
  logic [7:0]  inc = '0;
  logic [15:0] mem_addr, len_o, src_o, dst_o;
  logic        mem_re, mem_we, busy, armed, done, src_upd;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_dma_engine u0 (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .mode_i (mode),
    .len_i (len), .src_i (src), .dst_i (dst), .inc_i (inc),
    .data_wr_i (data_wr), .fill_word_i (fill_word),
    .mem_addr_o (mem_addr), .mem_re_o (mem_re), .mem_we_o (mem_we),
    .mem_wdata_o (mem_wdata), .mem_rdata_i (mem_rdata),
    .busy_o (busy), .armed_o (armed), .done_o (done), .src_upd_o (src_upd),
    .len_o (len_o), .src_o (src_o), .dst_o (dst_o)
  );

  typedef struct packed {logic wr; logic [15:0] addr; logic [7:0] data;} acc_t;
  acc_t  exp_q[$];
  acc_t  got;
  int    checks = 0, fails = 0;
  string cur_req = "R2";

  function automatic logic [7:0] ram_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  always_ff @(posedge clk) if (mem_re) mem_rdata <= ram_f(mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: every RAM access must match the head of the expected list
  always @(negedge clk) begin
    if (rst_n && (mem_re || mem_we)) begin
      chk(!(mem_re && mem_we), "R4", "re and we together", {mem_re, mem_we}, 2'b00);
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected access", {mem_we, mem_addr, mem_wdata}, 0);
      end else begin
        got = exp_q.pop_front();
        chk(mem_we == got.wr && mem_addr == got.addr && (!got.wr || mem_wdata == got.data),
            cur_req, "access", {mem_we, mem_addr, mem_wdata}, got);
      end
    end
  end

  task automatic wait_done(output int busy_cnt, input bit poke);
    busy_cnt = 0;
    forever begin
      if (done) break;
      if (busy) busy_cnt++;
      if (poke && busy_cnt == 2) begin
        start = 1'b1; mode = 1'b1; len = 16'd7; src = 16'h1234; dst = 16'h4321; inc = 8'd9;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_copy(input logic [15:0] s, d, l, input logic [7:0] i, input bit poke);
    int n = (l == 0) ? 65536 : int'(l);
    logic [15:0] ss = s, dd = d;
    int bc;
    cur_req = "R2";
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({1'b0, ss, 8'h00});
      exp_q.push_back({1'b1, dd, ram_f(ss)});
      ss = ss + 16'd1;
      dd = dd + 16'(i);
    end
    @(negedge clk);
    start = 1'b1; mode = 1'b0; src = s; dst = d; len = l; inc = i;
    @(negedge clk);
    start = 1'b0;
    wait_done(bc, poke);
    chk(bc == 2*n, poke ? "R8" : "R5", "copy busy cycles", bc, 2*n);
    chk(len_o == 16'h0, "R6", "copy len writeback", len_o, 0);
    chk(src_o == ss, "R6", "copy src writeback", src_o, ss);
    chk(dst_o == dd, "R6", "copy dst writeback", dst_o, dd);
    chk(src_upd == 1'b1, "R6", "copy src_upd", src_upd, 1);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R5", "done one cycle", {done, busy}, 0);
  endtask

  task automatic run_fill(input logic [15:0] d, l, w, input logic [7:0] i, input bit poke);
    int n = (l == 0) ? 65536 : int'(l);
    logic [15:0] dd = d;
    int bc;
    cur_req = "R3";
    exp_q.push_back({1'b1, d, w[7:0]});
    for (int k = 0; k < n; k++) begin
      exp_q.push_back({1'b1, dd ^ 16'd1, w[15:8]});
      dd = dd + 16'(i);
    end
    @(negedge clk);
    start = 1'b1; mode = 1'b1; dst = d; len = l; inc = i; src = 16'hBEEF;
    @(negedge clk);
    start = 1'b0;
    chk(armed && !busy, "R7", "armed without access", {armed, busy}, 2'b10);
    if (poke) begin
      start = 1'b1; mode = 1'b0; dst = 16'h0777; len = 16'd2; inc = 8'd5;
      @(negedge clk);
      start = 1'b0;
      chk(armed && !busy, "R8", "start while armed ignored", {armed, busy}, 2'b10);
      dst = 16'h0; len = 16'd1; inc = 8'd0;
    end
    @(negedge clk);
    data_wr = 1'b1; fill_word = w;
    @(negedge clk);
    data_wr = 1'b0; fill_word = 16'h0;
    wait_done(bc, 1'b0);
    chk(bc == n + 1, (l == 0) ? "R1" : "R5", "fill busy cycles", bc, n + 1);
    chk(!armed, "R7", "armed cleared at end", armed, 0);
    chk(len_o == 16'h0, "R6", "fill len writeback", len_o, 0);
    chk(dst_o == dd, "R6", "fill dst writeback", dst_o, dd);
    chk(src_upd == 1'b0, "R6", "fill src_upd", src_upd, 0);
    @(negedge clk);
    chk(done == 1'b0, "R5", "fill done one cycle", done, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R9";
    chk(!busy && !armed && !done && !mem_re && !mem_we, "R9", "state in reset",
        {busy, armed, done, mem_re, mem_we}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !armed && !done && !mem_re && !mem_we, "R9", "state after reset",
        {busy, armed, done, mem_re, mem_we}, 0);

    run_copy(16'h0100, 16'h2000, 16'd4, 8'd1, 1'b0);   // R2 plain copy
    run_copy(16'hFFFE, 16'hFFFF, 16'd3, 8'd3, 1'b0);   // R2 source and destination wrap
    run_copy(16'h0040, 16'h8000, 16'd6, 8'd2, 1'b1);   // R8 start during copy
    run_copy(16'h1111, 16'h3333, 16'd1, 8'd0, 1'b0);   // R2 single step, zero increment

    run_fill(16'h0100, 16'd3, 16'hA55A, 8'd2, 1'b0);   // R3 even start
    run_fill(16'h0201, 16'd2, 16'h1234, 8'd1, 1'b1);   // R3 odd start, R8 start while armed
    run_fill(16'hFFFF, 16'd2, 16'h7E81, 8'd4, 1'b0);   // R3 destination wrap

    // R7: data write while not armed must produce no access
    cur_req = "R7";
    @(negedge clk);
    data_wr = 1'b1; fill_word = 16'hFFFF;
    @(negedge clk);
    data_wr = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !armed && !done, "R7", "data write when idle", {busy, armed, done}, 0);

    run_fill(16'h0010, 16'd0, 16'hC3D2, 8'd1, 1'b0);   // R1 zero length = 65536 steps

    chk(exp_q.size() == 0, "R2", "expected accesses left", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule